// File: doc/BRIEF.md
# Hex Keypad Memory Monitor

This block is the control core of a tiny hardware memory editor driven by a hex keypad. It holds a 16-bit memory pointer and takes in already-debounced key codes. Hex digits are shifted into the byte at the pointer, one nibble at a time. Four command keys move the pointer or request execution. The pointer and the byte it addresses are presented as six display nibbles for a seven-segment driver.

Memory is reached through a plain synchronous port with one cycle of read latency. The block drives the pointer onto the address lines at all times. A hex digit therefore costs a read cycle followed by a write cycle. The GO command does not run anything: it emits a single-cycle pulse with the fixed base address, and surrounding logic decides what to do with it.

After any key is taken, the block ignores the keypad until it has seen the no-key indication. This keeps a held key from repeating.

Top module: `keypad_monitor`

## Requirements
- R1: While `rst` is high and afterwards until a key is taken, the pointer equals {BASE_PAGE, 8'h00}, `mem_we` is low and `go_pulse` is low.
- R2: A key code 0 to 15 performs exactly one memory write, to the pointer address, of ((old byte << 4) | code) truncated to 8 bits, so digits shift in from the right. The pointer is unchanged.
- R3: Key code 17 (accept) adds one to the full 16-bit pointer, carrying from the low byte into the high byte when the low byte wraps from 8'hFF to 8'h00.
- R4: Key code 18 (step back within page) subtracts one from the pointer low byte only; the high byte never changes, so 8'h00 wraps to 8'hFF within the same page.
- R5: Key code 19 (step back both) subtracts one from the high byte and one from the low byte with no borrow between them. This moves back one location when the low byte was 8'h00 and back 257 locations otherwise.
- R6: Key code 16 (GO) raises `go_pulse` for exactly one cycle with `go_addr` equal to {BASE_PAGE, 8'h00}, and leaves the pointer and memory unchanged.
- R7: Once a key with code 0 to 19 has been taken, no further key (whatever its code) has any effect until `key_down` has been observed low.
- R8: `disp_nibbles` shows the pointer high byte in bits 23:16, the pointer low byte in bits 15:8 and the byte stored at the pointer in bits 7:0, each byte most significant nibble first.
- R9: Key codes 20 to 31 have no effect on the pointer, the memory or `go_pulse`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| key_down | input | 1 | High while a debounced key is pressed |
| key_code | input | 5 | Code of the pressed key, valid while key_down is high |
| mem_addr | output | 16 | Memory address, always the pointer |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, one cycle after the address |
| disp_nibbles | output | 24 | Six display nibbles: pointer high, pointer low, data |
| go_pulse | output | 1 | One-cycle execute request |
| go_addr | output | 16 | Address carried by the execute request |

## Verification
Every cycle, the assertions check the pointer arithmetic of each command: the carry on accept, the high byte held on the in-page step and the borrow-free double decrement. They also check that writes and GO requests last one cycle only. Some behaviours exist only as an order of events, so only the bench scenarios can show them. These are the shifted value that lands in memory after a read followed by a write, the lockout while a key is held, the silence of unused codes, and the display catching up with the pointer and the stored byte.

// File: rtl/kpm_pkg.sv
package kpm_pkg;
  localparam int KEY_W = 5;

  localparam logic [KEY_W-1:0] KC_GO        = 5'd16;
  localparam logic [KEY_W-1:0] KC_ACCEPT    = 5'd17;
  localparam logic [KEY_W-1:0] KC_BACK_LO   = 5'd18;
  localparam logic [KEY_W-1:0] KC_BACK_BOTH = 5'd19;

  typedef enum logic [1:0] {
    PTR_HOLD,
    PTR_INC,
    PTR_DEC_LO,
    PTR_DEC_BOTH
  } ptr_op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ,
    ST_WRITE,
    ST_RELEASE
  } ctl_state_e;
endpackage

// File: rtl/kpm_ptr.sv
module kpm_ptr
  import kpm_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter logic [BYTE_W-1:0] BASE_PAGE = 8'h02
) (
  input  logic              clk,
  input  logic              rst,
  input  ptr_op_e           op,
  output logic [BYTE_W-1:0] ptr_hi,
  output logic [BYTE_W-1:0] ptr_lo
);
  localparam int ADDR_W = 2 * BYTE_W;

  logic [ADDR_W-1:0] ptr_plus_one;
  assign ptr_plus_one = {ptr_hi, ptr_lo} + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_hi <= BASE_PAGE;
      ptr_lo <= '0;
    end else begin
      case (op)
        PTR_INC:      {ptr_hi, ptr_lo} <= ptr_plus_one;
        PTR_DEC_LO:   ptr_lo <= ptr_lo - 1'b1;
        PTR_DEC_BOTH: begin
          ptr_hi <= ptr_hi - 1'b1;
          ptr_lo <= ptr_lo - 1'b1;
        end
        default: ;
      endcase
    end
  end

  // R3: wrap of the low byte carries into the high byte
  assert_inc_carry_R3: assert property (@(posedge clk) disable iff (rst)
    (op == PTR_INC && ptr_lo == '1) |=> (ptr_lo == '0 && ptr_hi == $past(ptr_hi) + 1'b1));

  // R4: in-page step never touches the high byte
  assert_declo_page_kept_R4: assert property (@(posedge clk) disable iff (rst)
    (op == PTR_DEC_LO) |=> (ptr_hi == $past(ptr_hi) && ptr_lo == $past(ptr_lo) - 1'b1));

  // R5: both bytes drop by one with no borrow between them
  assert_decboth_no_borrow_R5: assert property (@(posedge clk) disable iff (rst)
    (op == PTR_DEC_BOTH) |=> (ptr_hi == $past(ptr_hi) - 1'b1 && ptr_lo == $past(ptr_lo) - 1'b1));
endmodule

// File: rtl/kpm_ctrl.sv
module kpm_ctrl
  import kpm_pkg::*;
#(
  parameter int NIB_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             key_down,
  input  logic [KEY_W-1:0] key_code,
  output ptr_op_e          ptr_op,
  output logic [NIB_W-1:0] nib,
  output logic             wr_en,
  output logic             go_pulse
);
  ctl_state_e state_q, state_d;
  logic       go_d;
  logic       is_hex;

  assign is_hex = (key_code < KC_GO);

  always_comb begin
    state_d = state_q;
    ptr_op  = PTR_HOLD;
    go_d    = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (key_down) begin
          if (is_hex) begin
            state_d = ST_READ;
          end else if (key_code == KC_GO) begin
            go_d    = 1'b1;
            state_d = ST_RELEASE;
          end else if (key_code == KC_ACCEPT) begin
            ptr_op  = PTR_INC;
            state_d = ST_RELEASE;
          end else if (key_code == KC_BACK_LO) begin
            ptr_op  = PTR_DEC_LO;
            state_d = ST_RELEASE;
          end else if (key_code == KC_BACK_BOTH) begin
            ptr_op  = PTR_DEC_BOTH;
            state_d = ST_RELEASE;
          end
        end
      end
      ST_READ:    state_d = ST_WRITE;
      ST_WRITE:   state_d = ST_RELEASE;
      ST_RELEASE: if (!key_down) state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      nib      <= '0;
      go_pulse <= 1'b0;
    end else begin
      state_q  <= state_d;
      go_pulse <= go_d;
      if (state_q == ST_IDLE && key_down && is_hex)
        nib <= key_code[NIB_W-1:0];
    end
  end

  assign wr_en = (state_q == ST_WRITE);

  // R7: a held key cannot move the pointer again
  assert_no_action_while_locked_R7: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RELEASE) |-> (ptr_op == PTR_HOLD && !go_d));
endmodule

// File: rtl/kpm_disp.sv
module kpm_disp #(
  parameter int BYTE_W = 8,
  parameter int N_BYTES = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [N_BYTES*BYTE_W-1:0] fields,
  output logic [N_BYTES*BYTE_W-1:0] disp
);
  for (genvar g = 0; g < N_BYTES; g++) begin : g_field
    always_ff @(posedge clk) begin
      if (rst) disp[g*BYTE_W +: BYTE_W] <= '0;
      else     disp[g*BYTE_W +: BYTE_W] <= fields[g*BYTE_W +: BYTE_W];
    end
  end
endmodule

// File: rtl/keypad_monitor.sv
module keypad_monitor
  import kpm_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter logic [BYTE_W-1:0] BASE_PAGE = 8'h02
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                key_down,
  input  logic [KEY_W-1:0]    key_code,
  output logic [2*BYTE_W-1:0] mem_addr,
  output logic                mem_we,
  output logic [BYTE_W-1:0]   mem_wdata,
  input  logic [BYTE_W-1:0]   mem_rdata,
  output logic [3*BYTE_W-1:0] disp_nibbles,
  output logic                go_pulse,
  output logic [2*BYTE_W-1:0] go_addr
);
  localparam int ADDR_W = 2 * BYTE_W;
  localparam int NIB_W  = BYTE_W / 2;
  localparam int DISP_W = 3 * BYTE_W;

  ptr_op_e           ptr_op;
  logic [BYTE_W-1:0] ptr_hi, ptr_lo;
  logic [NIB_W-1:0]  nib;
  logic [DISP_W-1:0] fields;

  kpm_ctrl #(.NIB_W(NIB_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .key_down (key_down),
    .key_code (key_code),
    .ptr_op   (ptr_op),
    .nib      (nib),
    .wr_en    (mem_we),
    .go_pulse (go_pulse)
  );

  kpm_ptr #(.BYTE_W(BYTE_W), .BASE_PAGE(BASE_PAGE)) u_ptr (
    .clk    (clk),
    .rst    (rst),
    .op     (ptr_op),
    .ptr_hi (ptr_hi),
    .ptr_lo (ptr_lo)
  );

  assign fields = {ptr_hi, ptr_lo, mem_rdata};

  kpm_disp #(.BYTE_W(BYTE_W), .N_BYTES(3)) u_disp (
    .clk    (clk),
    .rst    (rst),
    .fields (fields),
    .disp   (disp_nibbles)
  );

  assign mem_addr  = {ptr_hi, ptr_lo};
  assign mem_wdata = {mem_rdata[NIB_W-1:0], nib};
  assign go_addr   = {BASE_PAGE, {BYTE_W{1'b0}}};

  // R2: one write per hex key, never back to back
  assert_single_write_R2: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we);

  // R2: the address is steady across the write
  assert_write_addr_steady_R2: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> $stable(mem_addr));

  // R6: execute request is a single cycle
  assert_go_single_R6: assert property (@(posedge clk) disable iff (rst)
    go_pulse |=> !go_pulse);

  // R6: GO leaves the pointer where it was
  assert_go_ptr_kept_R6: assert property (@(posedge clk) disable iff (rst)
    go_pulse |-> $stable(mem_addr));
endmodule

// File: tb/tb_keypad_monitor.sv
module tb_keypad_monitor;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        key_down = 1'b0;
  logic [4:0]  key_code = '0;
  logic [15:0] mem_addr;
  logic        mem_we;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata;
  logic [23:0] disp_nibbles;
  logic        go_pulse;
  logic [15:0] go_addr;

  always #2.5 clk = ~clk;

  keypad_monitor dut (
    .clk(clk), .rst(rst), .key_down(key_down), .key_code(key_code),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .disp_nibbles(disp_nibbles),
    .go_pulse(go_pulse), .go_addr(go_addr)
  );

  logic [7:0] bmem [0:1023];
  logic [7:0] expm [0:1023];
  int wr_cnt = 0;
  int go_cnt = 0;

  always @(posedge clk) begin
    mem_rdata <= bmem[mem_addr[9:0]];
    if (mem_we) begin
      bmem[mem_addr[9:0]] <= mem_wdata;
      wr_cnt <= wr_cnt + 1;
    end
    if (go_pulse) go_cnt <= go_cnt + 1;
  end

  int nchk = 0;
  int nfail = 0;
  logic [15:0] eptr;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic press(input logic [4:0] code, input int hold);
    @(negedge clk);
    key_down = 1'b1;
    key_code = code;
    repeat (hold) @(negedge clk);
    key_down = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  function automatic logic [7:0] shifted(input logic [7:0] old, input logic [4:0] code);
    return {old[3:0], code[3:0]};
  endfunction

  // {key code, expected pointer after the key}
  localparam logic [20:0] VEC [13] = '{
    {5'd10, 16'h0200}, {5'd5,  16'h0200}, {5'd17, 16'h0201},
    {5'd3,  16'h0201}, {5'd18, 16'h0200}, {5'd18, 16'h02FF},
    {5'd17, 16'h0300}, {5'd19, 16'h02FF}, {5'd19, 16'h01FE},
    {5'd12, 16'h01FE}, {5'd17, 16'h01FF}, {5'd17, 16'h0200},
    {5'd25, 16'h0200}
  };

  function automatic string tag_of(input logic [4:0] c);
    if (c < 5'd16) return "R2";
    if (c == 5'd17) return "R3";
    if (c == 5'd18) return "R4";
    if (c == 5'd19) return "R5";
    return "R9";
  endfunction

  bit done = 1'b0;

  initial begin
    #400000;
    if (!done) begin
      nfail++;
      nchk++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 1024; i++) begin
      bmem[i] = 8'((i * 37 + 5) & 255);
      expm[i] = 8'((i * 37 + 5) & 255);
    end
    repeat (4) @(negedge clk);
    // R1: state held during reset
    chk(mem_addr == 16'h0200, "R1", 32'(mem_addr), 32'h0200);
    chk(!mem_we && !go_pulse, "R1", {30'd0, mem_we, go_pulse}, 32'd0);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    eptr = 16'h0200;
    // R1, R8: pointer and the stored byte shown after reset
    chk(disp_nibbles == {eptr, expm[eptr[9:0]]}, "R1", 32'(disp_nibbles), {8'd0, eptr, expm[eptr[9:0]]});

    for (int i = 0; i < 13; i++) begin
      logic [4:0] c;
      int wbefore;
      c = VEC[i][20:16];
      wbefore = wr_cnt;
      press(c, 3);
      if (c < 5'd16) expm[eptr[9:0]] = shifted(expm[eptr[9:0]], c);
      eptr = VEC[i][15:0];
      // R8: display shows pointer high, pointer low, data
      chk(disp_nibbles == {eptr, expm[eptr[9:0]]}, tag_of(c), 32'(disp_nibbles), {8'd0, eptr, expm[eptr[9:0]]});
      chk(wr_cnt - wbefore == ((c < 5'd16) ? 1 : 0), tag_of(c), 32'(wr_cnt - wbefore), (c < 5'd16) ? 32'd1 : 32'd0);
    end

    // R7: hex key held for many cycles shifts in only once
    begin
      int wb;
      wb = wr_cnt;
      press(5'd7, 12);
      expm[eptr[9:0]] = shifted(expm[eptr[9:0]], 5'd7);
      chk(wr_cnt - wb == 1, "R7", 32'(wr_cnt - wb), 32'd1);
      chk(disp_nibbles == {eptr, expm[eptr[9:0]]}, "R7", 32'(disp_nibbles), {8'd0, eptr, expm[eptr[9:0]]});
    end

    // R7: accept held long advances once; code changes while held are ignored
    @(negedge clk);
    key_down = 1'b1;
    key_code = 5'd17;
    repeat (5) @(negedge clk);
    key_code = 5'd4;
    repeat (5) @(negedge clk);
    key_code = 5'd19;
    repeat (5) @(negedge clk);
    key_down = 1'b0;
    repeat (6) @(negedge clk);
    eptr = eptr + 16'd1;
    chk(disp_nibbles == {eptr, expm[eptr[9:0]]}, "R7", 32'(disp_nibbles), {8'd0, eptr, expm[eptr[9:0]]});

    // R6: GO pulse
    begin
      int gb;
      int wb;
      int hi_cnt;
      logic [15:0] seen_addr;
      gb = go_cnt;
      wb = wr_cnt;
      hi_cnt = 0;
      seen_addr = '0;
      @(negedge clk);
      key_down = 1'b1;
      key_code = 5'd16;
      for (int k = 0; k < 8; k++) begin
        @(negedge clk);
        if (go_pulse) begin
          hi_cnt++;
          seen_addr = go_addr;
        end
      end
      key_down = 1'b0;
      repeat (6) @(negedge clk);
      chk(hi_cnt == 1 && go_cnt - gb == 1, "R6", 32'(hi_cnt), 32'd1);
      chk(seen_addr == 16'h0200, "R6", 32'(seen_addr), 32'h0200);
      chk(wr_cnt == wb && disp_nibbles == {eptr, expm[eptr[9:0]]}, "R6", 32'(disp_nibbles), {8'd0, eptr, expm[eptr[9:0]]});
    end

    // R9: top unused code does nothing, then a normal key still works
    press(5'd31, 3);
    chk(disp_nibbles == {eptr, expm[eptr[9:0]]} && go_cnt == 1, "R9", 32'(disp_nibbles), {8'd0, eptr, expm[eptr[9:0]]});
    press(5'd17, 1);
    eptr = eptr + 16'd1;
    chk(disp_nibbles == {eptr, expm[eptr[9:0]]}, "R3", 32'(disp_nibbles), {8'd0, eptr, expm[eptr[9:0]]});

    // R1: reset in mid-session restores the base pointer
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    chk(disp_nibbles[23:8] == 16'h0200, "R1", 32'(disp_nibbles[23:8]), 32'h0200);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule